// File: doc/BRIEF.md
# DMA Handshake Ready Generator

This block drives the transmit-ready and receive-ready handshake pins that an external DMA engine watches for each serial channel. Each channel reports two counts from its FIFOs: how many transmit slots are free and how many received characters are waiting. A per-channel FIFO-enable bit and a per-channel transfer-mode bit choose between two behaviours. In single-character mode (mode bit clear, or FIFOs disabled), the pins follow the counts directly. In block mode (FIFOs enabled and mode bit set), the pins assert at a programmable trigger level and release only at the opposite boundary of the FIFO.

Each direction of each channel is a two-state machine. The receive machine has the states `RX_IDLE` (pin inactive) and `RX_ARMED` (pin active). Its transitions are `IDLE->ARMED` on arm, and `ARMED->IDLE` on drain when the fill count reaches zero. The arm condition is a non-zero fill in single mode, or a fill at or above the trigger in block mode. The transmit machine has the states `TX_HOLD` (pin inactive) and `TX_OPEN` (pin active). Its transitions are `HOLD->OPEN` on space and `OPEN->HOLD` on close. Space means a completely empty FIFO in single mode, or free space at or above the trigger in block mode. Close means the FIFO is no longer completely empty in single mode, or completely full in block mode. The pins are taken straight from the state flops, so they cannot glitch.

An 8-bit status word gathers the ready state of every channel, so software can poll all of them in one read.

Top module: `dmardy_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every `txrdy_n` and `rxrdy_n` pin is high (inactive) and `rdy_status` is zero.
- R2: In single mode, with FIFOs enabled and the mode bit 0, `rxrdy_n` is low in the cycle after `rx_fill` is non-zero and high in the cycle after it is zero. All pins update one clock after the counts they depend on.
- R3: In single mode, `txrdy_n` is low in the cycle after `tx_free` equals DEPTH (transmit FIFO empty), and high otherwise.
- R4: In block mode (FIFO enable 1 and mode bit 1), `rxrdy_n` goes low in the cycle after `rx_fill` reaches or exceeds `rx_trig`.
- R5: In block mode, once `rxrdy_n` is low it stays low while `rx_fill` is non-zero, even below `rx_trig`. It returns high in the cycle after `rx_fill` is zero.
- R6: In block mode, `txrdy_n` goes low in the cycle after `tx_free` reaches or exceeds `tx_trig`.
- R7: In block mode, once `txrdy_n` is low it stays low while `tx_free` is non-zero. It returns high in the cycle after `tx_free` is zero (FIFO full).
- R8: With the FIFO enable bit 0, the channel behaves in single mode whatever its mode bit holds.
- R9: A trigger value of 0 acts as a trigger of 1.
- R10: `rdy_status` bit k is 1 when channel k's transmit pin is active, and bit 4+k is 1 when its receive pin is active. Bits of channels that do not exist read 0. The word changes in the same cycle as the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | NUM_CH | Per-channel FIFO enable |
| dma_mode | input | NUM_CH | Per-channel transfer mode (0 single, 1 block) |
| tx_trig | input | NUM_CH x CNT_W | Per-channel transmit trigger (free slots) |
| rx_trig | input | NUM_CH x CNT_W | Per-channel receive trigger (filled slots) |
| tx_free | input | NUM_CH x CNT_W | Free slots in each transmit FIFO |
| rx_fill | input | NUM_CH x CNT_W | Characters held in each receive FIFO |
| txrdy_n | output | NUM_CH | Active-low transmit-ready pins |
| rxrdy_n | output | NUM_CH | Active-low receive-ready pins |
| rdy_status | output | 8 | Combined active-high ready word |

## Verification
Each channel is swept separately through every combination of FIFO enable and mode bit, across a set of trigger values that includes 0 and DEPTH. For each combination the receive count and then the free count are ramped from 0 up to DEPTH and back down to 0. On the upward ramp, the exact step where a pin asserts tells the trigger comparison apart from the single-mode test of non-zero or empty. On the downward ramp, a pin that stays active below the trigger shows the block-mode hold, and only block mode shows it. The idle channel sits at fixed counts throughout, so the status word checks both the bit packing and that the channels do not interfere.

// File: rtl/dmardy_pkg.sv
package dmardy_pkg;
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_ARMED = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_HOLD = 1'b0,
        TX_OPEN = 1'b1
    } tx_state_e;

    localparam int STATUS_W     = 8;
    localparam int STATUS_SLOTS = STATUS_W / 2;
endpackage

// File: rtl/dmardy_rx_fsm.sv
module dmardy_rx_fsm
    import dmardy_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             block_mode,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] trig,
    output logic             rdy_n
);
    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] eff_trig;
    logic             arm;

    assign eff_trig = (trig == '0) ? CNT_W'(1) : trig;
    assign arm      = block_mode ? (fill >= eff_trig) : (fill != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (arm)          state_d = RX_ARMED;
            RX_ARMED: if (fill == '0)   state_d = RX_IDLE;
            default:                    state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rdy_n = (state_q != RX_ARMED);
    end

    // R2
    rx_empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> rdy_n);
    // R4
    rx_trigger_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_mode && fill >= eff_trig) |=> !rdy_n);
    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && fill != '0) |=> !rdy_n);
endmodule

// File: rtl/dmardy_tx_fsm.sv
module dmardy_tx_fsm
    import dmardy_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             block_mode,
    input  logic [CNT_W-1:0] free,
    input  logic [CNT_W-1:0] trig,
    output logic             rdy_n
);
    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] eff_trig;
    logic             space, close;

    assign eff_trig = (trig == '0) ? CNT_W'(1) : trig;
    assign space    = block_mode ? (free >= eff_trig) : (free == FULL_FREE);
    assign close    = block_mode ? (free == '0)       : (free != FULL_FREE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_HOLD: if (space) state_d = TX_OPEN;
            TX_OPEN: if (close) state_d = TX_HOLD;
            default:            state_d = TX_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        rdy_n = (state_q != TX_OPEN);
    end

    // R3
    tx_empty_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!block_mode && free == FULL_FREE) |=> !rdy_n);
    // R6
    tx_trigger_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_mode && free >= eff_trig) |=> !rdy_n);
    // R7
    tx_full_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free == '0) |=> rdy_n);
endmodule

// File: rtl/dmardy_status_pack.sv
module dmardy_status_pack
    import dmardy_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0]   tx_rdy_n,
    input  logic [NUM_CH-1:0]   rx_rdy_n,
    output logic [STATUS_W-1:0] status
);
    for (genvar k = 0; k < STATUS_SLOTS; k++) begin : g_slot
        if (k < NUM_CH) begin : g_live
            assign status[k]                = ~tx_rdy_n[k];
            assign status[STATUS_SLOTS + k] = ~rx_rdy_n[k];
        end else begin : g_absent
            assign status[k]                = 1'b0;
            assign status[STATUS_SLOTS + k] = 1'b0;
        end
    end
endmodule

// File: rtl/dmardy_gen.sv
module dmardy_gen
    import dmardy_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             fifo_en,
    input  logic [NUM_CH-1:0]             dma_mode,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  tx_trig,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rx_trig,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  tx_free,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rx_fill,
    output logic [NUM_CH-1:0]             txrdy_n,
    output logic [NUM_CH-1:0]             rxrdy_n,
    output logic [STATUS_W-1:0]           rdy_status
);
    logic [NUM_CH-1:0] block_mode;

    assign block_mode = fifo_en & dma_mode;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmardy_rx_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .block_mode (block_mode[c]),
            .fill       (rx_fill[c]),
            .trig       (rx_trig[c]),
            .rdy_n      (rxrdy_n[c])
        );

        dmardy_tx_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .block_mode (block_mode[c]),
            .free       (tx_free[c]),
            .trig       (tx_trig[c]),
            .rdy_n      (txrdy_n[c])
        );

        // R10
        status_tx_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_status[c] == !txrdy_n[c]);
        // R10
        status_rx_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_status[STATUS_SLOTS + c] == !rxrdy_n[c]);
    end

    dmardy_status_pack #(.NUM_CH(NUM_CH)) u_pack (
        .tx_rdy_n (txrdy_n),
        .rx_rdy_n (rxrdy_n),
        .status   (rdy_status)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (&txrdy_n && &rxrdy_n && rdy_status == '0));
endmodule

// File: tb/dmardy_gen_test.sv
module dmardy_gen_test;
    localparam int NUM_CH = 2;
    localparam int DEPTH  = 64;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [NUM_CH-1:0]            fifo_en = '0;
    logic [NUM_CH-1:0]            dma_mode = '0;
    logic [NUM_CH-1:0][CNT_W-1:0] tx_trig = '0;
    logic [NUM_CH-1:0][CNT_W-1:0] rx_trig = '0;
    logic [NUM_CH-1:0][CNT_W-1:0] tx_free = '0;
    logic [NUM_CH-1:0][CNT_W-1:0] rx_fill = '0;
    logic [NUM_CH-1:0]            txrdy_n;
    logic [NUM_CH-1:0]            rxrdy_n;
    logic [7:0]                   rdy_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dmardy_gen #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_free(tx_free), .rx_fill(rx_fill),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .rdy_status(rdy_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Swept channel ch, other channel idle in single mode with empty TX FIFO.
    task automatic verify(input int ch, input bit etx, input bit erx, input string req);
        logic [7:0] es;
        es = '0;
        es[ch]     = etx;
        es[4 + ch] = erx;
        es[1 - ch] = 1'b1;
        check(txrdy_n[ch] == !etx, req, int'(txrdy_n[ch]), int'(!etx));
        check(rxrdy_n[ch] == !erx, req, int'(rxrdy_n[ch]), int'(!erx));
        check(rdy_status == es, "R10", int'(rdy_status), int'(es));
    endtask

    initial begin
        int trigs[7] = '{0, 1, 8, 16, 33, 63, 64};
        tx_free = '{CNT_W'(DEPTH), CNT_W'(DEPTH)};
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check(txrdy_n == '1 && rxrdy_n == '1, "R1", int'({txrdy_n, rxrdy_n}), 15);
        check(rdy_status == 8'h00, "R1", int'(rdy_status), 0);
        rst_n = 1'b1;
        // R1 first cycle after reset release
        check(rdy_status == 8'h00, "R1", int'(rdy_status), 0);
        step();

        for (int ch = 0; ch < NUM_CH; ch++) begin
            for (int fe = 0; fe < 2; fe++) begin
                for (int md = 0; md < 2; md++) begin
                    for (int ti = 0; ti < 7; ti++) begin
                        bit    blk;
                        int    eff;
                        string up_rx, dn_rx, up_tx, dn_tx;
                        blk = (fe == 1) && (md == 1);
                        eff = (trigs[ti] == 0) ? 1 : trigs[ti];
                        up_rx = blk ? (trigs[ti] == 0 ? "R9" : "R4") : (fe == 0 ? "R8" : "R2");
                        dn_rx = blk ? "R5" : (fe == 0 ? "R8" : "R2");
                        up_tx = blk ? (trigs[ti] == 0 ? "R9" : "R6") : (fe == 0 ? "R8" : "R3");
                        dn_tx = blk ? "R7" : (fe == 0 ? "R8" : "R3");

                        fifo_en  = '0;
                        dma_mode = '0;
                        fifo_en[ch]  = fe[0];
                        dma_mode[ch] = md[0];
                        tx_trig = '0;
                        rx_trig = '0;
                        tx_trig[ch] = CNT_W'(trigs[ti]);
                        rx_trig[ch] = CNT_W'(trigs[ti]);
                        rx_fill = '0;
                        tx_free = '{CNT_W'(DEPTH), CNT_W'(DEPTH)};
                        step();
                        step();

                        for (int v = 0; v <= DEPTH; v++) begin
                            rx_fill[ch] = CNT_W'(v);
                            step();
                            verify(ch, 1'b1, blk ? (v >= eff) : (v != 0), up_rx);
                        end
                        for (int v = DEPTH - 1; v >= 0; v--) begin
                            rx_fill[ch] = CNT_W'(v);
                            step();
                            verify(ch, 1'b1, v != 0, dn_rx);
                        end

                        tx_free[ch] = '0;
                        step();
                        for (int v = 0; v <= DEPTH; v++) begin
                            tx_free[ch] = CNT_W'(v);
                            step();
                            verify(ch, blk ? (v >= eff) : (v == DEPTH), 1'b0, up_tx);
                        end
                        for (int v = DEPTH - 1; v >= 0; v--) begin
                            tx_free[ch] = CNT_W'(v);
                            step();
                            verify(ch, blk ? (v != 0) : 1'b0, 1'b0, dn_tx);
                        end
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule